// File: doc/BRIEF.md
# Multi-Bank Request Router with Per-Bank Conflict Queues

This block accepts up to four load or store requests per clock from the processor side. It spreads them over several single-ported cache banks. The bank is chosen from the line address, so neighbouring cache lines fall into neighbouring banks. Each bank has a short queue in front of it. The queue holds requests that land on the same bank in the same cycle, so they wait there instead of being turned away. A request is refused only when its bank's queue has no room. A refused request is simply dropped, and the requester must present it again.

Each bank works on one access at a time, with a fixed latency. When an access finishes, the entries queued right behind it are compared against its line. Entries that belong to the same line retire in the same cycle and share that single access. Entries for other lines wait for their own turn.

Completions come out on independent response lanes, one lane per queue slot per bank. Each lane carries the number of the port that issued the request, the request ID and the data. The bank storage here is a plain fixed-latency memory with one full cache line per row. Tags, misses and refill are not part of this block.

Top module: `bank_router`

## Requirements
- R1: Addresses are word addresses (32-bit words, 8 words per line). The word within the line is addr[2:0], the line is addr[9:3], and the bank is the line modulo NBANK, which is addr[4:3] by default. A completion appears on lane bank*K+slot, where slot 0 is the entry at the head of the queue.
- R2: Up to four requests aimed at distinct banks are all accepted in the same cycle. Into idle banks, they all complete in the same cycle.
- R3: A valid request is ready when its bank's free space exceeds the number of lower-numbered valid ports aimed at the same bank in that cycle. Free space is the queue depth (4) minus the occupancy at the start of the cycle. Acceptance therefore goes in ascending port order. A refused request is never queued and never completes.
- R4: A request accepted into an empty, idle bank has its response registered LAT+1 clock edges after the accepting edge, which is 3 edges by default.
- R5: When the head access completes, entries in slots 1..K-1 that directly follow the head retire in the same cycle, on slots 1, 2 and onward, with data from the same line. This holds only while the head is a load and each entry addresses the head's line. The first entry to a different line ends the group.
- R6: Groups in one bank are serialized. The next group completes LAT+1 edges after the previous one, and no bank completes in two consecutive cycles.
- R7: A store ends its group. A store at the head completes alone. Loads in the same group as a store return the line's value from before the write, while later loads see the written word. The response to a store echoes its write data.
- R8: Each completion carries the originating port number and the request ID, and every accepted request completes exactly once.
- R9: After reset no response lane is valid and every queue is empty, so four requests to one bank are all accepted in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Request present, one bit per port |
| req_write | input | NPORT | 1 = store, 0 = load, per port |
| req_addr | input | NPORT*AW | Word address, port p at bits p*AW |
| req_wdata | input | NPORT*DW | Store data per port |
| req_id | input | NPORT*IDW | Request ID per port |
| req_ready | output | NPORT | Request accepted this cycle (combinational) |
| rsp_valid | output | NBANK*K | Completion on lane bank*K+slot |
| rsp_port | output | NBANK*K*PW | Originating port per lane |
| rsp_id | output | NBANK*K*IDW | Request ID per lane |
| rsp_rdata | output | NBANK*K*DW | Load data, or echoed store data |

## Verification
The assertions assume that a refused request is treated by its source as not sent. They also assume that inputs are held steady across the clock edge, so the combinational ready seen in a cycle matches what the queues record. The stimulus changes requests only at the falling edge and samples ready just after. It never reads a word it has not first written, because the line memory is not reset. Request IDs stay unique within the run, so completions can be matched to requests one to one.

// File: rtl/brr_pkg.sv
package brr_pkg;
  typedef enum logic {ENG_IDLE = 1'b0, ENG_BUSY = 1'b1} eng_t;
endpackage

// File: rtl/brr_xbar.sv
module brr_xbar #(
  parameter int NPORT  = 4,
  parameter int NBANK  = 4,
  parameter int FDEPTH = 4,
  localparam int BB = $clog2(NBANK),
  localparam int CW = $clog2(FDEPTH + 1),
  localparam int PW = $clog2(NPORT)
) (
  input  logic [NPORT-1:0]            req_vld,
  input  logic [NPORT-1:0][BB-1:0]    bsel,
  input  logic [NBANK-1:0][CW-1:0]    free_cnt,
  output logic [NPORT-1:0]            req_rdy,
  output logic [NBANK-1:0][NPORT-1:0] push_vld,
  output logic [NPORT-1:0][PW-1:0]    push_rank
);
  int rank;

  always_comb begin
    req_rdy   = '0;
    push_vld  = '0;
    push_rank = '0;
    for (int p = 0; p < NPORT; p++) begin
      rank = 0;
      for (int q = 0; q < p; q++)
        if (req_vld[q] && bsel[q] == bsel[p]) rank = rank + 1;
      push_rank[p] = PW'(rank);
      req_rdy[p]   = req_vld[p] && (rank < int'(free_cnt[bsel[p]]));
      if (req_rdy[p]) push_vld[bsel[p]][p] = 1'b1;
    end
  end
endmodule

// File: rtl/brr_bank.sv
module brr_bank
  import brr_pkg::*;
#(
  parameter int NPORT      = 4,
  parameter int NBANK      = 4,
  parameter int LINE_BYTES = 32,
  parameter int AW         = 10,
  parameter int DW         = 32,
  parameter int IDW        = 6,
  parameter int FDEPTH     = 4,
  parameter int MK         = 4,
  parameter int LAT        = 2,
  localparam int WPL  = LINE_BYTES / (DW / 8),
  localparam int WOB  = $clog2(WPL),
  localparam int BB   = $clog2(NBANK),
  localparam int RB   = AW - WOB - BB,
  localparam int ROWS = 1 << RB,
  localparam int CW   = $clog2(FDEPTH + 1),
  localparam int IW   = $clog2(FDEPTH),
  localparam int PW   = $clog2(NPORT),
  localparam int LCW  = $clog2(LAT + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPORT-1:0]           push_vld,
  input  logic [NPORT-1:0][PW-1:0]   push_rank,
  input  logic [NPORT-1:0]           push_wr,
  input  logic [NPORT-1:0][AW-1:0]   push_addr,
  input  logic [NPORT-1:0][DW-1:0]   push_data,
  input  logic [NPORT-1:0][IDW-1:0]  push_id,
  output logic [CW-1:0]              free_cnt,
  output logic [MK-1:0]              rsp_vld,
  output logic [MK-1:0][PW-1:0]      rsp_port,
  output logic [MK-1:0][IDW-1:0]     rsp_id,
  output logic [MK-1:0][DW-1:0]      rsp_data
);
  // queue storage, slot 0 is the head (the entry in service)
  logic [FDEPTH-1:0]          q_wr,   n_wr;
  logic [FDEPTH-1:0][AW-1:0]  q_wa,   n_wa;
  logic [FDEPTH-1:0][DW-1:0]  q_data, n_data;
  logic [FDEPTH-1:0][PW-1:0]  q_port, n_port;
  logic [FDEPTH-1:0][IDW-1:0] q_id,   n_id;
  logic [CW-1:0]              cnt,    n_cnt;

  eng_t                       state;
  logic [LCW-1:0]             lat_cnt;
  logic                       done;
  logic [WPL-1:0][DW-1:0]     mem [ROWS];
  logic [WPL-1:0][DW-1:0]     line_q;

  logic [MK-1:0]              take;
  logic                       stop, st_vld;
  logic [WOB-1:0]             st_word;
  logic [DW-1:0]              st_data;
  int                         npop, base, idx, npush;

  assign free_cnt = CW'(FDEPTH) - cnt;
  assign done     = (state == ENG_BUSY) && (lat_cnt == LCW'(LAT - 1));

  // group selection at completion: head plus contiguous same-line followers
  always_comb begin
    take    = '0;
    take[0] = done;
    stop    = q_wr[0];
    st_vld  = done && q_wr[0];
    st_word = q_wa[0][WOB-1:0];
    st_data = q_data[0];
    for (int j = 1; j < MK; j++) begin
      if (done && !stop && j < int'(cnt) &&
          q_wa[j][AW-1:WOB] == q_wa[0][AW-1:WOB]) begin
        take[j] = 1'b1;
        if (q_wr[j]) begin
          stop    = 1'b1;
          st_vld  = 1'b1;
          st_word = q_wa[j][WOB-1:0];
          st_data = q_data[j];
        end
      end else begin
        stop = 1'b1;
      end
    end
    npop = $countones(take);
  end

  // queue update: retire the group, then append accepted pushes by rank
  always_comb begin
    n_wr = q_wr; n_wa = q_wa; n_data = q_data; n_port = q_port; n_id = q_id;
    for (int i = 0; i < FDEPTH; i++) begin
      if (i + npop < FDEPTH) begin
        n_wr[i]   = q_wr[IW'(i + npop)];
        n_wa[i]   = q_wa[IW'(i + npop)];
        n_data[i] = q_data[IW'(i + npop)];
        n_port[i] = q_port[IW'(i + npop)];
        n_id[i]   = q_id[IW'(i + npop)];
      end
    end
    base  = int'(cnt) - npop;
    npush = 0;
    idx   = 0;
    for (int p = 0; p < NPORT; p++) begin
      if (push_vld[p]) begin
        idx = base + int'(push_rank[p]);
        if (idx < FDEPTH) begin
          n_wr[IW'(idx)]   = push_wr[p];
          n_wa[IW'(idx)]   = push_addr[p];
          n_data[IW'(idx)] = push_data[p];
          n_port[IW'(idx)] = PW'(p);
          n_id[IW'(idx)]   = push_id[p];
        end
        npush = npush + 1;
      end
    end
    n_cnt = CW'(base + npush);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      state   <= ENG_IDLE;
      lat_cnt <= '0;
      rsp_vld <= '0;
    end else begin
      cnt     <= n_cnt;
      rsp_vld <= take;
      if (state == ENG_IDLE) begin
        if (cnt != '0) begin
          state   <= ENG_BUSY;
          lat_cnt <= '0;
        end
      end else if (done) begin
        state <= ENG_IDLE;
      end else begin
        lat_cnt <= lat_cnt + LCW'(1);
      end
    end
    q_wr <= n_wr; q_wa <= n_wa; q_data <= n_data; q_port <= n_port; q_id <= n_id;
    for (int j = 0; j < MK; j++) begin
      rsp_port[j] <= q_port[j];
      rsp_id[j]   <= q_id[j];
      rsp_data[j] <= q_wr[j] ? q_data[j] : line_q[q_wa[j][WOB-1:0]];
    end
  end

  // line memory: one read at access start, one word write at completion
  always_ff @(posedge clk) begin
    if (state == ENG_IDLE && cnt != '0)
      line_q <= mem[q_wa[0][AW-1:WOB+BB]];
    if (st_vld)
      mem[q_wa[0][AW-1:WOB+BB]][st_word] <= st_data;
  end

  // R3: queue occupancy never exceeds its depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= FDEPTH);
  // R6: one access in service implies an entry at the head
  a_r6_busy_has_head: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_BUSY) |-> (cnt != '0));
  // R5: retired slots always form a prefix starting at slot 0
  a_r5_lane_prefix: assert property (@(posedge clk) disable iff (rst)
    ((rsp_vld + MK'(1)) & rsp_vld) == '0);
  // R6: a bank never completes in two consecutive cycles
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    rsp_vld[0] |=> !rsp_vld[0]);
  // R9: reset leaves the bank empty and quiet
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (rsp_vld == '0 && cnt == '0));
endmodule

// File: rtl/bank_router.sv
module bank_router #(
  parameter int NPORT      = 4,
  parameter int NBANK      = 4,
  parameter int LINE_BYTES = 32,
  parameter int AW         = 10,
  parameter int DW         = 32,
  parameter int IDW        = 6,
  parameter int FDEPTH     = 4,
  parameter int MK         = 4,
  parameter int LAT        = 2,
  localparam int NL  = NBANK * MK,
  localparam int PW  = $clog2(NPORT),
  localparam int WOB = $clog2(LINE_BYTES / (DW / 8)),
  localparam int BB  = $clog2(NBANK),
  localparam int CW  = $clog2(FDEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORT-1:0]     req_valid,
  input  logic [NPORT-1:0]     req_write,
  input  logic [NPORT*AW-1:0]  req_addr,
  input  logic [NPORT*DW-1:0]  req_wdata,
  input  logic [NPORT*IDW-1:0] req_id,
  output logic [NPORT-1:0]     req_ready,
  output logic [NL-1:0]        rsp_valid,
  output logic [NL*PW-1:0]     rsp_port,
  output logic [NL*IDW-1:0]    rsp_id,
  output logic [NL*DW-1:0]     rsp_rdata
);
  logic [NPORT-1:0][BB-1:0]    bsel;
  logic [NBANK-1:0][CW-1:0]    free_cnt;
  logic [NBANK-1:0][NPORT-1:0] push_vld;
  logic [NPORT-1:0][PW-1:0]    push_rank;

  for (genvar p = 0; p < NPORT; p++) begin : g_sel
    assign bsel[p] = req_addr[p*AW+WOB +: BB];
    if (p > 0) begin : g_ord
      // R3: a higher port never wins a bank slot over a lower valid port
      a_r3_port_order: assert property (@(posedge clk) disable iff (rst)
        (req_valid[p-1] && req_ready[p] && bsel[p-1] == bsel[p]) |-> req_ready[p-1]);
    end
  end

  brr_xbar #(.NPORT(NPORT), .NBANK(NBANK), .FDEPTH(FDEPTH)) i_xbar (
    .req_vld(req_valid), .bsel(bsel), .free_cnt(free_cnt),
    .req_rdy(req_ready), .push_vld(push_vld), .push_rank(push_rank));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    brr_bank #(
      .NPORT(NPORT), .NBANK(NBANK), .LINE_BYTES(LINE_BYTES), .AW(AW), .DW(DW),
      .IDW(IDW), .FDEPTH(FDEPTH), .MK(MK), .LAT(LAT)
    ) i_bank (
      .clk(clk), .rst(rst),
      .push_vld(push_vld[b]), .push_rank(push_rank),
      .push_wr(req_write), .push_addr(req_addr),
      .push_data(req_wdata), .push_id(req_id),
      .free_cnt(free_cnt[b]),
      .rsp_vld(rsp_valid[b*MK +: MK]),
      .rsp_port(rsp_port[b*MK*PW +: MK*PW]),
      .rsp_id(rsp_id[b*MK*IDW +: MK*IDW]),
      .rsp_data(rsp_rdata[b*MK*DW +: MK*DW]));
  end
endmodule

// File: tb/test_bank_router.sv
`timescale 1ns/1ps
module test_bank_router;
  localparam int NL = 16;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req_valid = '0;
  logic [3:0]  req_write = '0;
  logic [39:0] req_addr  = '0;
  logic [127:0] req_wdata = '0;
  logic [23:0] req_id    = '0;
  logic [3:0]  req_ready;
  logic [NL-1:0]    rsp_valid;
  logic [NL*2-1:0]  rsp_port;
  logic [NL*6-1:0]  rsp_id;
  logic [NL*32-1:0] rsp_rdata;

  bank_router i_bank_router (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_id(req_id),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_port(rsp_port),
    .rsp_id(rsp_id), .rsp_rdata(rsp_rdata));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, acc = 0, acc1 = 0, mid = 0;
  logic [3:0]  rdy_s;
  int          rec_cnt  [64];
  int          rec_cyc  [64];
  int          rec_lane [64];
  int          rec_port [64];
  logic [31:0] rec_data [64];
  logic [31:0] shadow   [1024];
  logic [31:0] e0;

  // {write, word address, data}
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 10'h000, 32'hAAAA0000}, {1'b1, 10'h009, 32'h11112222},
    {1'b1, 10'h012, 32'h33334444}, {1'b1, 10'h01B, 32'h55556666},
    {1'b1, 10'h020, 32'h77778888}, {1'b0, 10'h009, 32'h0},
    {1'b0, 10'h020, 32'h0},        {1'b0, 10'h000, 32'h0},
    {1'b1, 10'h000, 32'h9999AAAA}, {1'b0, 10'h000, 32'h0},
    {1'b0, 10'h01B, 32'h0},        {1'b0, 10'h012, 32'h0}};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      for (int l = 0; l < NL; l++) begin
        if (rsp_valid[l]) begin
          mid = int'(rsp_id[l*6 +: 6]);
          rec_cnt[mid]  = rec_cnt[mid] + 1;
          rec_cyc[mid]  = cyc;
          rec_lane[mid] = l;
          rec_port[mid] = int'(rsp_port[l*2 +: 2]);
          rec_data[mid] = rsp_rdata[l*32 +: 32];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input int p, input bit wr, input logic [9:0] a,
                         input logic [31:0] d, input int id);
    req_valid[p] = 1'b1;
    req_write[p] = wr;
    req_addr[p*10 +: 10]  = a;
    req_wdata[p*32 +: 32] = d;
    req_id[p*6 +: 6]      = 6'(id);
  endtask

  task automatic send();
    #1;
    rdy_s = req_ready;
    acc   = cyc;
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
  endtask

  task automatic chk_rsp(input int id, input string tag, input int port, input int lane,
                         input logic [31:0] data, input int base, input int dly);
    chk({tag, " count"}, 64'(rec_cnt[id]), 64'd1);
    chk({tag, " data"},  64'(rec_data[id]), 64'(data));
    chk({tag, " port"},  64'(rec_port[id]), 64'(port));
    chk({tag, " lane"},  64'(rec_lane[id]), 64'(lane));
    chk({tag, " cycle"}, 64'(rec_cyc[id] - base), 64'(dly));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) rec_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: quiet after reset
    chk("R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);

    // R9/R3/R6/R7: four stores to one bank, all fit; stores never merge
    for (int p = 0; p < 4; p++) set_req(p, 1'b1, 10'(p + 1), 32'hC0DE0001 + 32'(p), 24 + p);
    send();
    chk("R9 R3 empty queue takes four", 64'(rdy_s), 64'hF);
    for (int p = 0; p < 4; p++) shadow[p + 1] = 32'hC0DE0001 + 32'(p);
    repeat (16) @(negedge clk);
    for (int p = 0; p < 4; p++)
      chk_rsp(24 + p, "R6 R7 serial stores", p, 0, 32'hC0DE0001 + 32'(p), acc, 4 + 3 * p);

    // R1/R4/R8: vector table, one request at a time
    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp;
      set_req(i % 4, VEC[i][42], VEC[i][41:32], VEC[i][31:0], i);
      send();
      if (VEC[i][42]) begin
        exp = VEC[i][31:0];
        shadow[VEC[i][41:32]] = exp;
      end else begin
        exp = shadow[VEC[i][41:32]];
      end
      repeat (6) @(negedge clk);
      chk_rsp(i, "R1 R4 R8 table", i % 4, 4 * int'(VEC[i][36:35]), exp, acc, 4);
    end

    // R2: four distinct banks in one cycle
    set_req(0, 1'b0, 10'h000, 0, 20); set_req(1, 1'b0, 10'h009, 0, 21);
    set_req(2, 1'b0, 10'h012, 0, 22); set_req(3, 1'b0, 10'h01B, 0, 23);
    send();
    chk("R2 all ready", 64'(rdy_s), 64'hF);
    repeat (8) @(negedge clk);
    chk_rsp(20, "R2 bank0", 0, 0,  shadow[10'h000], acc, 4);
    chk_rsp(21, "R2 bank1", 1, 4,  shadow[10'h009], acc, 4);
    chk_rsp(22, "R2 bank2", 2, 8,  shadow[10'h012], acc, 4);
    chk_rsp(23, "R2 bank3", 3, 12, shadow[10'h01B], acc, 4);

    // R5: four loads to one line merge into one completion
    for (int p = 0; p < 4; p++) set_req(p, 1'b0, 10'(p), 0, 28 + p);
    send();
    repeat (8) @(negedge clk);
    for (int p = 0; p < 4; p++)
      chk_rsp(28 + p, "R5 same-line merge", p, p, shadow[p], acc, 4);

    // R7: load, store, load to one word
    e0 = shadow[10'h001];
    set_req(0, 1'b0, 10'h001, 0, 32);
    set_req(1, 1'b1, 10'h001, 32'hDEADBEEF, 33);
    set_req(2, 1'b0, 10'h001, 0, 34);
    send();
    shadow[10'h001] = 32'hDEADBEEF;
    repeat (12) @(negedge clk);
    chk_rsp(32, "R7 older load sees old", 0, 0, e0, acc, 4);
    chk_rsp(33, "R7 store joins group", 1, 1, 32'hDEADBEEF, acc, 4);
    chk_rsp(34, "R7 younger load sees new", 2, 0, 32'hDEADBEEF, acc, 7);

    // R6: different line in between blocks merging
    set_req(0, 1'b0, 10'h000, 0, 35);
    set_req(1, 1'b0, 10'h020, 0, 36);
    set_req(2, 1'b0, 10'h002, 0, 37);
    send();
    repeat (14) @(negedge clk);
    chk_rsp(35, "R6 first line", 0, 0, shadow[10'h000], acc, 4);
    chk_rsp(36, "R6 other line", 1, 0, shadow[10'h020], acc, 7);
    chk_rsp(37, "R6 no skip-ahead merge", 2, 0, shadow[10'h002], acc, 10);

    // R3: partial room, ascending port order, refused never completes
    set_req(0, 1'b0, 10'h012, 0, 40);
    set_req(1, 1'b1, 10'h013, 32'h0BADF00D, 41);
    send();
    acc1 = acc;
    chk("R3 first pair ready", 64'(rdy_s), 64'h3);
    for (int p = 0; p < 4; p++) set_req(p, 1'b0, 10'h012, 0, 42 + p);
    send();
    chk("R3 only two slots free", 64'(rdy_s), 64'h3);
    shadow[10'h013] = 32'h0BADF00D;
    repeat (12) @(negedge clk);
    chk_rsp(40, "R3 load head", 0, 8, shadow[10'h012], acc1, 4);
    chk_rsp(41, "R7 store echo", 1, 9, 32'h0BADF00D, acc1, 4);
    chk_rsp(42, "R3 accepted port0", 0, 8, shadow[10'h012], acc1, 7);
    chk_rsp(43, "R3 accepted port1", 1, 9, shadow[10'h012], acc1, 7);
    chk("R3 refused port2 absent", 64'(rec_cnt[44]), 64'd0);
    chk("R3 refused port3 absent", 64'(rec_cnt[45]), 64'd0);

    // R8: every accepted request completed exactly once
    begin
      int errs = 0;
      for (int i = 0; i < 44; i++) begin
        if ((i < 12 || i >= 20) && i != 38 && i != 39 && rec_cnt[i] != 1) errs++;
      end
      chk("R8 exactly once", 64'(errs), 64'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule